// File: doc/BRIEF.md
# UART Banked Register Access Controller

This block is the register front end of a 16550-style UART. A CPU reaches it over a 3-bit address with an 8-bit write bus, a registered 8-bit read bus, and one-cycle write and read strobes. The line control register (LCR) sits at address 3. Writing the key value 0xBF to it swaps address 2 from its base-bank register into a hidden shadow bank. In that bank, address 2 holds the enhanced feature register (EFR). Any other LCR value restores the base bank, and the value written is the line configuration that the rest of the UART uses.

EFR bit 4 is the extension enable. While it is 0, the upper, non-standard fields of IER, MCR and EFR keep their stored contents on a write. The standard low fields are written as usual. Reads always return the stored bits.

Two MCR bits drive the serial side:
- Bit 6 turns on infrared mode and forces the transmit idle level low.
- Bit 7 sets the baud prescaler. The block divides its clock by 16 and, when bit 7 is set, by a further 4. It emits the result as a one-cycle enable pulse for the baud divisor that follows.

Top module: `uart_regbank_ctrl`

## Requirements
- R1: After reset, IER, LCR, MCR, EFR and the base address-2 register read 0x00, `line_cfg` is 0x00, `ir_en` is 0, `tx_idle_lvl` is 1 and the base bank is selected.
- R2: Writing 0xBF to address 3 selects the shadow bank. Address 2 then reads and writes EFR, and address 3 still reads back the LCR value.
- R3: Writing any other value to address 3 selects the base bank and drives that value on `line_cfg` from the next cycle. Address 2 then reaches the base register, and such writes leave EFR unchanged.
- R4: While EFR bit 4 is 0, writes leave IER bits 7:4, MCR bits 7:5 and EFR bits 7:5 at their stored values. The remaining bits are written.
- R5: While EFR bit 4 is 1, every bit of IER, MCR and EFR is written.
- R6: A read strobe in cycle N places the addressed register's stored value on `rdata` after the clock edge ending cycle N, whatever the state of EFR bit 4.
- R7: `ir_en` equals MCR bit 6 and `tx_idle_lvl` is its inverse, both updated on the edge that writes MCR.
- R8: With MCR bit 7 at 0, `baud_tick` is a one-cycle pulse every 16 clock cycles.
- R9: With MCR bit 7 at 1, `baud_tick` is a one-cycle pulse every 64 clock cycles.
- R10: Addresses 0, 5, 6 and 7 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Registered read data |
| line_cfg | output | 8 | Current line configuration (LCR contents) |
| ir_en | output | 1 | Infrared mode enable |
| tx_idle_lvl | output | 1 | Transmit idle level (0 in infrared mode) |
| baud_tick | output | 1 | Prescaled clock-enable pulse for the baud divisor |

## Verification
Register writes take effect on the edge that samples the strobe. The bench therefore drives strobes from one falling edge and reads the register state, `line_cfg`, `ir_en` and `tx_idle_lvl` at the next falling edge. Read data lands on the same edge as the read strobe, so `rdata` is compared one falling edge after the strobe is raised. `baud_tick` intervals are measured by counting falling edges between two sampled pulses, after the bench first locks onto a pulse so that a mode change cannot shorten the measured interval. The sweeps cover all 256 LCR values and all 256 IER and MCR values with the extension enable both clear and set, and the bench model computes each expected value arithmetically.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int RB_AW = 3;
  localparam int RB_DW = 8;

  localparam logic [RB_AW-1:0] A_IER = 3'd1;
  localparam logic [RB_AW-1:0] A_AUX = 3'd2;
  localparam logic [RB_AW-1:0] A_LCR = 3'd3;
  localparam logic [RB_AW-1:0] A_MCR = 3'd4;

  // fields that only the extension enable lets software change
  localparam logic [RB_DW-1:0] IER_EXT = 8'hF0;
  localparam logic [RB_DW-1:0] MCR_EXT = 8'hE0;
  localparam logic [RB_DW-1:0] EFR_EXT = 8'hE0;

  localparam int EFR_EN_BIT = 4;
  localparam int MCR_IR_BIT = 6;
  localparam int MCR_PS_BIT = 7;

  typedef struct packed {
    logic ier;
    logic aux;
    logic efr;
    logic lcr;
    logic mcr;
  } rb_sel_t;
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
(
  input  logic [RB_AW-1:0] addr,
  input  logic             shadow,
  output rb_sel_t          sel
);
  always_comb begin
    sel     = '0;
    sel.ier = (addr == A_IER);
    sel.lcr = (addr == A_LCR);
    sel.mcr = (addr == A_MCR);
    sel.efr = (addr == A_AUX) && shadow;
    sel.aux = (addr == A_AUX) && !shadow;
  end
endmodule

// File: rtl/uart_rb_regs.sv
module uart_rb_regs
  import uart_rb_pkg::*;
#(
  parameter logic [RB_DW-1:0] SHADOW_KEY = 8'hBF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [RB_DW-1:0] wdata,
  input  rb_sel_t          sel,
  output logic [RB_DW-1:0] ier_q,
  output logic [RB_DW-1:0] aux_q,
  output logic [RB_DW-1:0] efr_q,
  output logic [RB_DW-1:0] lcr_q,
  output logic [RB_DW-1:0] mcr_q,
  output logic             shadow_q,
  output logic [RB_DW-1:0] rdata
);
  logic             ext_en;
  logic [RB_DW-1:0] rd_mux;

  assign ext_en = efr_q[EFR_EN_BIT];

  function automatic logic [RB_DW-1:0] gated_merge(
    input logic [RB_DW-1:0] old_v,
    input logic [RB_DW-1:0] new_v,
    input logic [RB_DW-1:0] ext_mask,
    input logic             en
  );
    logic [RB_DW-1:0] keep;
    keep = en ? '0 : ext_mask;
    return (old_v & keep) | (new_v & ~keep);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q    <= '0;
      aux_q    <= '0;
      efr_q    <= '0;
      lcr_q    <= '0;
      mcr_q    <= '0;
      shadow_q <= 1'b0;
    end else if (wr_en) begin
      if (sel.ier) ier_q <= gated_merge(ier_q, wdata, IER_EXT, ext_en);
      if (sel.mcr) mcr_q <= gated_merge(mcr_q, wdata, MCR_EXT, ext_en);
      if (sel.efr) efr_q <= gated_merge(efr_q, wdata, EFR_EXT, ext_en);
      if (sel.aux) aux_q <= wdata;
      if (sel.lcr) begin
        lcr_q    <= wdata;
        shadow_q <= (wdata == SHADOW_KEY);
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel.ier) rd_mux = ier_q;
    if (sel.aux) rd_mux = aux_q;
    if (sel.efr) rd_mux = efr_q;
    if (sel.lcr) rd_mux = lcr_q;
    if (sel.mcr) rd_mux = mcr_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/uart_rb_prescale.sv
module uart_rb_prescale #(
  parameter int FIX_DIV = 16,
  parameter int EXT_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_sel,
  output logic tick
);
  localparam int FW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;
  localparam logic [FW-1:0] F_LAST = FW'(FIX_DIV - 1);

  logic [FW-1:0] fcnt;
  logic          fwrap;
  logic          ewrap;

  assign fwrap = (fcnt == F_LAST);

  always_ff @(posedge clk) begin
    if (rst)        fcnt <= '0;
    else if (fwrap) fcnt <= '0;
    else            fcnt <= fcnt + FW'(1);
  end

  generate
    if (EXT_DIV > 1) begin : g_ext
      localparam int EW = $clog2(EXT_DIV);
      localparam logic [EW-1:0] E_LAST = EW'(EXT_DIV - 1);
      logic [EW-1:0] ecnt;
      always_ff @(posedge clk) begin
        if (rst) ecnt <= '0;
        else if (fwrap) ecnt <= (ecnt == E_LAST) ? '0 : ecnt + EW'(1);
      end
      assign ewrap = (ecnt == E_LAST);
    end else begin : g_noext
      assign ewrap = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= fwrap && (!slow_sel || ewrap);
  end
endmodule

// File: rtl/uart_regbank_ctrl.sv
module uart_regbank_ctrl
  import uart_rb_pkg::*;
#(
  parameter logic [RB_DW-1:0] SHADOW_KEY = 8'hBF,
  parameter int               FIX_DIV    = 16,
  parameter int               EXT_DIV    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RB_AW-1:0] addr,
  input  logic [RB_DW-1:0] wdata,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [RB_DW-1:0] rdata,
  output logic [RB_DW-1:0] line_cfg,
  output logic             ir_en,
  output logic             tx_idle_lvl,
  output logic             baud_tick
);
  rb_sel_t          sel;
  logic             shadow_q;
  logic [RB_DW-1:0] ier_q, aux_q, efr_q, lcr_q, mcr_q;

  uart_rb_decode u_dec (
    .addr   (addr),
    .shadow (shadow_q),
    .sel    (sel)
  );

  uart_rb_regs #(.SHADOW_KEY(SHADOW_KEY)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .sel      (sel),
    .ier_q    (ier_q),
    .aux_q    (aux_q),
    .efr_q    (efr_q),
    .lcr_q    (lcr_q),
    .mcr_q    (mcr_q),
    .shadow_q (shadow_q),
    .rdata    (rdata)
  );

  uart_rb_prescale #(.FIX_DIV(FIX_DIV), .EXT_DIV(EXT_DIV)) u_ps (
    .clk      (clk),
    .rst      (rst),
    .slow_sel (mcr_q[MCR_PS_BIT]),
    .tick     (baud_tick)
  );

  assign line_cfg    = lcr_q;
  assign ir_en       = mcr_q[MCR_IR_BIT];
  assign tx_idle_lvl = ~mcr_q[MCR_IR_BIT];
endmodule

// File: rtl/uart_rb_chk.sv
module uart_rb_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic [7:0] line_cfg,
  input logic       ir_en,
  input logic       tx_idle_lvl,
  input logic       baud_tick,
  input logic       shadow,
  input logic [7:0] ier_q,
  input logic [7:0] mcr_q,
  input logic [7:0] efr_q
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (line_cfg == 8'h00 && !ir_en && tx_idle_lvl && !shadow));

  p_key_enters_shadow_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd3 && wdata == 8'hBF) |=> shadow);

  p_other_leaves_shadow_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd3 && wdata != 8'hBF) |=> (!shadow && line_cfg == $past(wdata)));

  p_base_write_spares_efr_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd2 && !shadow) |=> $stable(efr_q));

  p_ier_ext_held_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd1 && !efr_q[4]) |=> (ier_q[7:4] == $past(ier_q[7:4])));

  p_mcr_ext_held_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd4 && !efr_q[4]) |=> (mcr_q[7:5] == $past(mcr_q[7:5])));

  p_efr_ext_held_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd2 && shadow && !efr_q[4]) |=> (efr_q[7:5] == $past(efr_q[7:5])));

  p_ier_full_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd1 && efr_q[4]) |=> (ier_q == $past(wdata)));

  p_lcr_read_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd3) |=> (rdata == $past(line_cfg)));

  p_ir_rise_from_write_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_en) |-> $past(wr_en && addr == 3'd4 && wdata[6]));

  p_idle_opposes_ir_r7: assert property (@(posedge clk) disable iff (rst)
    ir_en != tx_idle_lvl);

  p_tick_single_r8: assert property (@(posedge clk) disable iff (rst)
    baud_tick |=> !baud_tick);
endmodule

bind uart_regbank_ctrl uart_rb_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr        (addr),
  .wdata       (wdata),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .rdata       (rdata),
  .line_cfg    (line_cfg),
  .ir_en       (ir_en),
  .tx_idle_lvl (tx_idle_lvl),
  .baud_tick   (baud_tick),
  .shadow      (shadow_q),
  .ier_q       (ier_q),
  .mcr_q       (mcr_q),
  .efr_q       (efr_q)
);

// File: tb/sim_uart_regbank_ctrl.sv
`timescale 1ns/1ps
module sim_uart_regbank_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata, line_cfg;
  logic       ir_en, tx_idle_lvl, baud_tick;

  int checks = 0;
  int errors = 0;

  // bench model of the register contents
  logic [7:0] m_ier = '0, m_aux = '0, m_efr = '0, m_lcr = '0, m_mcr = '0;

  always #4 clk = ~clk;

  uart_regbank_ctrl u0 (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .line_cfg(line_cfg), .ir_en(ir_en),
    .tx_idle_lvl(tx_idle_lvl), .baud_tick(baud_tick)
  );

  function automatic logic [7:0] wmerge(logic [7:0] o, logic [7:0] n,
                                        logic [7:0] m, logic en);
    return en ? n : ((o & m) | (n & ~m));
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    logic en;
    en = m_efr[4];
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd1: m_ier = wmerge(m_ier, d, 8'hF0, en);
      3'd2: if (m_lcr == 8'hBF) m_efr = wmerge(m_efr, d, 8'hE0, en);
            else m_aux = d;
      3'd3: m_lcr = d;
      3'd4: m_mcr = wmerge(m_mcr, d, 8'hE0, en);
      default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  function automatic logic [7:0] model_at2();
    return (m_lcr == 8'hBF) ? m_efr : m_aux;
  endfunction

  task automatic set_ext(logic en);
    logic [7:0] keep_lcr;
    keep_lcr = m_lcr;
    wr(3'd3, 8'hBF);
    wr(3'd2, en ? 8'h10 : 8'h00);
    wr(3'd3, keep_lcr);
  endtask

  task automatic measure(int exp, string tag);
    int n;
    n = 0;
    while (baud_tick !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk({tag, " pulse width"}, {7'd0, baud_tick}, 8'h00);
      n = 1;
      while (baud_tick !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
      chk({tag, " period"}, n[7:0], exp[7:0]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 line_cfg", line_cfg, 8'h00);
    chk("R1 ir_en", {7'd0, ir_en}, 8'h00);
    chk("R1 tx_idle_lvl", {7'd0, tx_idle_lvl}, 8'h01);
    chk("R1 rdata", rdata, 8'h00);
    for (int a = 1; a < 5; a++) rd(a[2:0], 8'h00, "R1 reg reset value");
    wr(3'd3, 8'hBF);
    rd(3'd2, 8'h00, "R1 EFR reset value");
    wr(3'd3, 8'h00);

    // R3: base write at address 2 must not reach EFR
    wr(3'd3, 8'h03);
    wr(3'd2, 8'hA5);
    rd(3'd2, 8'hA5, "R3 base reg at addr 2");
    wr(3'd3, 8'hBF);
    rd(3'd2, 8'h00, "R3 EFR untouched by base write");
    rd(3'd3, 8'hBF, "R2 LCR readable in shadow bank");
    wr(3'd2, 8'h1F);
    rd(3'd2, 8'h1F, "R2 EFR written in shadow bank");
    wr(3'd3, 8'h1B);
    rd(3'd2, 8'hA5, "R3 base reg restored after leaving shadow");

    // R2 R3: every LCR value
    for (int v = 0; v < 256; v++) begin
      wr(3'd3, v[7:0]);
      chk("R3 line_cfg follows LCR", line_cfg, v[7:0]);
      rd(3'd3, v[7:0], "R2 LCR readback");
      wr(3'd2, v[7:0] ^ 8'h3C);
      rd(3'd2, model_at2(), (v == 8'hBF) ? "R2 EFR via key" : "R3 base reg via addr 2");
    end

    // R4 R5 R6 R7: every IER and MCR value, extension off then on
    wr(3'd3, 8'h03);
    for (int e = 0; e < 2; e++) begin
      set_ext(e[0]);
      for (int v = 0; v < 256; v++) begin
        wr(3'd1, v[7:0]);
        rd(3'd1, m_ier, e ? "R5 IER full write" : "R4 IER ext held");
        wr(3'd4, v[7:0]);
        rd(3'd4, m_mcr, e ? "R5 MCR full write" : "R4 MCR ext held");
        chk("R7 ir_en", {7'd0, ir_en}, {7'd0, m_mcr[6]});
        chk("R7 tx_idle_lvl", {7'd0, tx_idle_lvl}, {7'd0, ~m_mcr[6]});
      end
      wr(3'd4, 8'h00);
    end

    // R4: EFR upper bits held while disabled
    set_ext(1'b1);
    wr(3'd3, 8'hBF);
    wr(3'd2, 8'hF0);
    rd(3'd2, 8'hF0, "R5 EFR full write");
    wr(3'd2, 8'h00);
    wr(3'd2, 8'hEF);
    rd(3'd2, 8'h0F, "R4 EFR ext held");
    rd(3'd2, m_efr, "R6 EFR read model");
    wr(3'd3, 8'h03);

    // R6: read value stable with extension off
    rd(3'd1, m_ier, "R6 IER readback ext off");

    // R10: unmapped addresses
    set_ext(1'b1);
    wr(3'd1, 8'h5A);
    wr(3'd4, 8'h21);
    for (int a = 0; a < 8; a++) begin
      if (a == 0 || a > 4) begin
        wr(a[2:0], 8'hFF);
        rd(a[2:0], 8'h00, "R10 unmapped read zero");
      end
    end
    rd(3'd1, 8'h5A, "R10 IER unchanged");
    rd(3'd3, 8'h03, "R10 LCR unchanged");
    rd(3'd4, 8'h21, "R10 MCR unchanged");
    rd(3'd2, m_aux, "R10 base reg unchanged");

    // R8 R9: prescaler
    wr(3'd4, 8'h00);
    measure(16, "R8 divide by 16");
    wr(3'd4, 8'h80);
    measure(64, "R9 divide by 64");
    wr(3'd4, 8'h00);
    measure(16, "R8 back to divide by 16");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule